// File: doc/BRIEF.md
# Indirect Register Window Controller

This block is the software-visible register front end of an I/O interrupt controller. Software reaches it through two directly addressed locations. It writes a selector value into the select location, then reads or writes the chosen internal register through the data window location. Behind the window sit three kinds of register: a 4-bit identification register, a read-only version word, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves through a pair of adjacent selector values.

Two bits in every entry belong to the delivery logic next door and not to software: the delivery-status bit and the remote-IRR bit. The delivery side sets and clears them through per-pin strobes. Software writes through the window leave them untouched. The one exception is that a write which leaves an entry edge-triggered also clears its remote-IRR bit. The whole table is exported as a flat vector for the delivery side to use. Reset leaves every entry masked.

Top module: `irw_ctrl`

## Requirements
- R1: A bus write whose low 8 address bits are 0x00 stores `bus_wdata[7:0]` as the selector. A read at offset 0x00 returns `{24'h0, selector}`. Address bits above bit 7 are ignored, so offset 0x100 aliases 0x00.
- R2: A window access with selector 0x01 reads the version word `{8'h00, NUM_PINS-1, 8'h00, 8'h20}`, which is 0x00170020 with the default 24 pins. Writes to it change nothing.
- R3: A window write with selector 0x00 stores `bus_wdata[27:24]` as the ID. A window read with selector 0x00 or 0x02 returns the ID in bits 27:24, with all other bits zero. A window write with selector 0x02 is ignored.
- R4: A selector of 0x10 or above addresses entry `(sel-0x10)>>1`. An odd selector reaches bits 63:32 and an even selector reaches bits 31:0. A read whose index is NUM_PINS or more, or whose selector lies in 0x03..0x0F, returns 0xFFFFFFFF. Writes to such a selector change no state.
- R5: A software write to an entry never changes its delivery-status bit (bit 12) or its remote-IRR bit (bit 14), apart from the clearing in R6.
- R6: After any software write to an entry whose trigger bit (bit 15, 0 = edge, 1 = level) ends up 0, the entry's remote-IRR bit is 0.
- R7: Reset clears the selector and the ID, and sets every entry to 0x0000_0000_0001_0000, so that only the mask bit (bit 16) is set.
- R8: A read at any low-8-bit offset other than 0x00 and 0x10 returns zero. A write there changes no state.
- R9: Read data appears on `bus_rdata` on the clock edge that samples the read request, so it is valid one cycle after the request. It holds its value until the next read.
- R10: `rirr_clr[i]` and `rirr_set[i]` update bit 14 of entry i, and `dlv_clr[i]` and `dlv_set[i]` update bit 12, on the next clock edge. When clear and set arrive together, clear wins.
- R11: `entry_tbl[64*i+63:64*i]` always shows entry i. Entry fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger 15, mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set strobe |
| rirr_clr | input | NUM_PINS | Per-pin remote-IRR clear strobe |
| dlv_set | input | NUM_PINS | Per-pin delivery-status set strobe |
| dlv_clr | input | NUM_PINS | Per-pin delivery-status clear strobe |
| entry_tbl | output | 64*NUM_PINS | All table entries, entry i at bits 64*i+63:64*i |

## Verification
The bench first sets both status bits of an entry through the strobes. It then rewrites each half of that entry with the status bits cleared in the write data. A design that copied the write data straight in would lose the bits. It then turns the entry edge-triggered and checks that remote-IRR drops while delivery status stays set. A design that forgot the edge rule would leave remote-IRR stuck high.

The bench reads the first selector past the table, the gap between 0x03 and 0x0F, and the last entry's upper half. An off-by-one in the index range check would return table data where all ones are expected, or all ones where data is expected. It also confirms that writes to those selectors leave the table unchanged. It checks aliasing of the upper address bits, the read-only version and arbitration selectors, and the rule that a simultaneous clear beats a set.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int SEL_W  = 8;
    localparam int DATA_W = 32;
    localparam int ENT_W  = 64;

    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    localparam logic [SEL_W-1:0] SEL_ID         = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VER        = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARB        = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TABLE_BASE = 8'h10;

    localparam logic [7:0] VERSION_CODE = 8'h20;

    typedef enum logic [2:0] {
        REG_ID,
        REG_VER,
        REG_ARB,
        REG_ENTRY,
        REG_NONE
    } reg_kind_e;

    // one redirection entry, MSB first
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;      // 0 edge, 1 level
        logic        rirr;
        logic        pol;
        logic        dlv;
        logic        dmode;
        logic [2:0]  dmod;
        logic [7:0]  vector;
    } redir_entry_t;

    function automatic redir_entry_t entry_reset_value();
        redir_entry_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    // replace one 32-bit half, keeping the two status bits
    function automatic redir_entry_t merge_half(redir_entry_t old_e,
                                                logic [DATA_W-1:0] wd,
                                                logic upper);
        redir_entry_t e;
        logic [ENT_W-1:0] raw;
        raw = old_e;
        if (upper) raw[ENT_W-1:DATA_W] = wd;
        else       raw[DATA_W-1:0]     = wd;
        e      = redir_entry_t'(raw);
        e.rirr = old_e.rirr;
        e.dlv  = old_e.dlv;
        return e;
    endfunction

endpackage

// File: rtl/irw_sel_decode.sv
module irw_sel_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [SEL_W-1:0] sel,
    output reg_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);
    logic [SEL_W-1:0] idx_full;

    always_comb begin
        idx_full = (sel - SEL_TABLE_BASE) >> 1;
        idx      = idx_full[IDX_W-1:0];
        upper    = sel[0];
        if (sel == SEL_ID)                                      kind = REG_ID;
        else if (sel == SEL_VER)                                kind = REG_VER;
        else if (sel == SEL_ARB)                                kind = REG_ARB;
        else if (sel >= SEL_TABLE_BASE && int'(idx_full) < NUM_PINS) kind = REG_ENTRY;
        else                                                    kind = REG_NONE;
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_upper,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rirr_set,
    input  logic              rirr_clr,
    input  logic              dlv_set,
    input  logic              dlv_clr,
    output redir_entry_t      ent
);
    redir_entry_t nxt;

    always_comb begin
        nxt = ent;
        if (wr_en) nxt = merge_half(ent, wr_data, wr_upper);
        if (rirr_clr || (wr_en && !nxt.trig)) nxt.rirr = 1'b0;
        else if (rirr_set)                     nxt.rirr = 1'b1;
        if (dlv_clr)      nxt.dlv = 1'b0;
        else if (dlv_set) nxt.dlv = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ent <= entry_reset_value();
        else     ent <= nxt;
    end

    AST_DLV_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dlv_set && !dlv_clr) |=> (ent.dlv == $past(ent.dlv)));        // R5
    AST_RIRR_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rirr_set && !rirr_clr) |=> (!ent.trig || ent.rirr == $past(ent.rirr))); // R5
    AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent.trig || !ent.rirr));                                       // R6
    AST_MASK_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ent.mask));                                            // R10
endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_valid,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_PINS-1:0]       rirr_set,
    input  logic [NUM_PINS-1:0]       rirr_clr,
    input  logic [NUM_PINS-1:0]       dlv_set,
    input  logic [NUM_PINS-1:0]       dlv_clr,
    output logic [ENT_W*NUM_PINS-1:0] entry_tbl
);
    localparam int         IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

    logic [7:0]       ofs;
    logic             wr_sel, wr_win, rd_req;
    logic [SEL_W-1:0] sel_q;
    logic [3:0]       id_q;
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             upper;
    redir_entry_t     ents [NUM_PINS];
    logic [ENT_W-1:0] sel_ent;
    logic [DATA_W-1:0] win_rdata;
    logic             unused_addr;

    assign ofs         = bus_addr[7:0];
    assign unused_addr = ^bus_addr;
    assign wr_sel      = bus_valid && bus_we && (ofs == OFS_SELECT);
    assign wr_win      = bus_valid && bus_we && (ofs == OFS_WINDOW);
    assign rd_req      = bus_valid && !bus_we;

    irw_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) dec_i (
        .sel(sel_q), .kind(kind), .idx(idx), .upper(upper)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
            if (wr_win && kind == REG_ID) id_q <= bus_wdata[27:24];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        irw_entry ent_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_win && kind == REG_ENTRY && idx == IDX_W'(i)),
            .wr_upper (upper),
            .wr_data  (bus_wdata),
            .rirr_set (rirr_set[i]),
            .rirr_clr (rirr_clr[i]),
            .dlv_set  (dlv_set[i]),
            .dlv_clr  (dlv_clr[i]),
            .ent      (ents[i])
        );
        assign entry_tbl[ENT_W*i +: ENT_W] = ents[i];
    end

    always_comb begin
        sel_ent = ents[idx];
        case (kind)
            REG_ID, REG_ARB: win_rdata = {4'h0, id_q, 24'h0};
            REG_VER:         win_rdata = {8'h00, PIN_MAX, 8'h00, VERSION_CODE};
            REG_ENTRY:       win_rdata = upper ? sel_ent[ENT_W-1:DATA_W] : sel_ent[DATA_W-1:0];
            default:         win_rdata = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (rd_req) begin
            case (ofs)
                OFS_SELECT: bus_rdata <= {{(DATA_W-SEL_W){1'b0}}, sel_q};
                OFS_WINDOW: bus_rdata <= win_rdata;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(bus_rdata));                                          // R9
    AST_ID_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ofs == OFS_WINDOW && sel_q == SEL_ARB)
        |=> (bus_rdata[23:0] == 24'h0 && bus_rdata[31:28] == 4'h0));             // R3
    AST_PAST_END_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ofs == OFS_WINDOW && sel_q >= SEL_TABLE_BASE
         && int'(sel_q[7:1]) - 8 >= NUM_PINS) |=> (bus_rdata == '1));             // R4
    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ofs != OFS_SELECT && ofs != OFS_WINDOW) |=> (bus_rdata == '0)); // R8
endmodule

// File: tb/irw_ctrl_tb.sv
module irw_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dlv_set = '0, dlv_clr = '0;
    logic [64*NP-1:0] entry_tbl;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [63:0] m_tbl [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    irw_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr), .dlv_set(dlv_set), .dlv_clr(dlv_clr),
        .entry_tbl(entry_tbl)
    );

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
        m_sel = 8'h00;
        m_id  = 4'h0;
    endfunction

    function automatic logic [31:0] exp_window();
        int idx;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return {8'h00, 8'(NP-1), 8'h00, 8'h20};
        if (m_sel < 8'h10) return 32'hFFFF_FFFF;
        idx = (int'(m_sel) - 16) / 2;
        if (idx >= NP) return 32'hFFFF_FFFF;
        return m_sel[0] ? m_tbl[idx][63:32] : m_tbl[idx][31:0];
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] o);
        if (o == 8'h00) return {24'h0, m_sel};
        if (o == 8'h10) return exp_window();
        return 32'h0;
    endfunction

    function automatic void model_write(logic [7:0] o, logic [31:0] d);
        int idx;
        logic [63:0] n;
        if (o == 8'h00) m_sel = d[7:0];
        else if (o == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10) begin
                idx = (int'(m_sel) - 16) / 2;
                if (idx < NP) begin
                    n = m_tbl[idx];
                    if (m_sel[0]) n[63:32] = d; else n[31:0] = d;
                    n[12] = m_tbl[idx][12];
                    n[14] = m_tbl[idx][14];
                    if (!n[15]) n[14] = 1'b0;
                    m_tbl[idx] = n;
                end
            end
        end
    endfunction

    task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
        model_write(a[7:0], d);
    endtask

    task automatic bus_rd(logic [AW-1:0] a, string tag);
        logic [31:0] e;
        e = exp_read(a[7:0]);
        @(negedge clk);
        bus_valid = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        chk(tag, {32'h0, bus_rdata}, {32'h0, e});
    endtask

    task automatic status(int p, bit rs, bit rc, bit ds, bit dc);
        @(negedge clk);
        rirr_set[p] = rs; rirr_clr[p] = rc; dlv_set[p] = ds; dlv_clr[p] = dc;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0; dlv_set = '0; dlv_clr = '0;
        if (rc) m_tbl[p][14] = 1'b0; else if (rs) m_tbl[p][14] = 1'b1;
        if (dc) m_tbl[p][12] = 1'b0; else if (ds) m_tbl[p][12] = 1'b1;
    endtask

    task automatic chk_table(string tag);
        for (int i = 0; i < NP; i++) chk(tag, entry_tbl[64*i +: 64], m_tbl[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R7 reset state, R11 table export
        chk_table("R7 reset table / R11 export");
        bus_rd(12'h000, "R7 selector reset");
        bus_rd(12'h010, "R7 id reset");

        // R1 selector, aliasing of upper address bits
        bus_wr(12'h000, 32'h1234_56AB);
        bus_rd(12'h000, "R1 selector low 8 bits");
        bus_wr(12'h100, 32'h0000_0001);
        bus_rd(12'h300, "R1 upper address bits ignored");

        // R2 version
        chk("R2 version value", {32'h0, exp_window()}, 64'h0017_0020);
        bus_rd(12'h010, "R2 version read");
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_rd(12'h010, "R2 version write ignored");

        // R3 ID and arbitration selector
        bus_wr(12'h000, 32'h0);
        bus_wr(12'h010, 32'hA5FF_FFFF);
        bus_rd(12'h010, "R3 id readback");
        bus_wr(12'h000, 32'h2);
        bus_rd(12'h010, "R3 arb reads id");
        bus_wr(12'h010, 32'h0F00_0000);
        bus_rd(12'h010, "R3 arb write ignored");

        // R4 halves and range
        bus_wr(12'h000, 32'h10);
        bus_wr(12'h010, 32'h0000_F031);
        bus_rd(12'h010, "R4 entry0 low, status bits masked");
        bus_wr(12'h000, 32'h11);
        bus_wr(12'h010, 32'hDE00_0000);
        bus_rd(12'h010, "R4 entry0 high");
        bus_wr(12'h000, 32'h3F);
        bus_wr(12'h010, 32'h7700_0000);
        bus_rd(12'h010, "R4 last entry high");
        bus_wr(12'h000, 32'h40);
        bus_wr(12'h010, 32'h1234_5678);
        bus_rd(12'h010, "R4 first selector past table reads ones");
        bus_wr(12'h000, 32'h05);
        bus_wr(12'h010, 32'h0);
        bus_rd(12'h010, "R4 gap selector reads ones");
        chk_table("R4 out-of-range writes ignored");

        // R5 / R10 status bits on a level entry (pin 3)
        bus_wr(12'h000, 32'h16);
        bus_wr(12'h010, 32'h0000_8040);
        status(3, 1, 0, 1, 0);
        bus_rd(12'h010, "R10 status set visible");
        bus_wr(12'h010, 32'h0001_8041);
        bus_rd(12'h010, "R5 low write keeps status");
        bus_wr(12'h000, 32'h17);
        bus_wr(12'h010, 32'h0300_0000);
        chk("R5 high write keeps status", entry_tbl[64*3 +: 64], m_tbl[3]);
        // R6 edge clears remote-IRR, delivery status stays
        bus_wr(12'h000, 32'h16);
        bus_wr(12'h010, 32'h0000_0041);
        bus_rd(12'h010, "R6 edge write clears rirr");
        chk("R6 rirr bit", {63'h0, entry_tbl[64*3+14]}, 64'h0);
        chk("R5 dlv survives edge write", {63'h0, entry_tbl[64*3+12]}, 64'h1);
        status(3, 1, 1, 1, 1);
        chk("R10 clear wins", entry_tbl[64*3 +: 64], m_tbl[3]);

        // R8 other offsets
        bus_wr(12'h020, 32'hFFFF_FFFF);
        bus_rd(12'h020, "R8 other offset reads zero");
        bus_rd(12'h000, "R8 other offset write ignored");

        // R9 hold
        bus_rd(12'h010, "R9 read data");
        last = bus_rdata;
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", {32'h0, bus_rdata}, {32'h0, last});

        // random mix
        for (int n = 0; n < 500; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3) bus_wr(12'h000, {$urandom(), 8'($urandom_range(0, 8'h45))} >> 0);
            else if (op < 6) bus_wr({4'($urandom()), 8'h10}, $urandom());
            else if (op < 8) bus_rd(12'h010, "R4 random window read");
            else if (op < 9) bus_rd(12'h000, "R1 random selector read");
            else status(int'($urandom_range(0, NP-1)), 1'($urandom()), 1'($urandom()),
                        1'($urandom()), 1'($urandom()));
        end
        chk_table("R11 final table");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule